// File: doc/BRIEF.md
# Endpoint Status Register with Bank Handshake

This block is the status and control word for one device-side endpoint of a USB-style function controller. Firmware uses it to launch transmit packets and to take ownership of a single receive bank. Completion of a transmit and arrival of a received packet are raised as flags. Each flag has its own interrupt enable. The received byte count appears in the same word while the bank is held by firmware.

The block sits between two clock domains. A simple write/read register port runs on the peripheral clock (`pclk`). Event strobes from the serial engine run on the USB clock (`uclk`). Commands travel in both directions through toggle-handshake synchronizers that carry a small payload.

A write that hands the receive bank back, or that arms a transmit, holds `busy` high until the command has reached the USB side and its acknowledge has come back. It also holds `busy` for at least a minimum number of peripheral cycles. Every other write holds `busy` for a short fixed window. Firmware waits for `busy` to fall before it touches the packet buffer.

Top module: `ep_status_reg`

## Requirements
- R1: After reset, `rd_data` reads 0, `irq`, `busy`, `usb_tx_req` and `usb_rx_nak` are low, and `usb_bank_free` is high.
- R2: Writing 1 to bit 2 (transmit-ready) while it is clear sets bit 2 and, after the crossing, raises `usb_tx_req`. A `usb_in_ack` strobe while `usb_tx_req` is high clears bit 2 and `usb_tx_req`, and sets bit 0 (transmit-done).
- R3: Writing 0 to bit 0 clears transmit-done. Writing 1 to bit 0 leaves it unchanged.
- R4: A `usb_rx_done` strobe while `usb_bank_free` is high drops `usb_bank_free` on the next `uclk` edge. It then sets bit 1 (bank-full) and places `usb_rx_count` in bits [15:8]. Bits [15:8] read 0 whenever bit 1 is clear.
- R5: Writing 0 to bit 1 while it is set clears it and returns the bank, so `usb_bank_free` goes high. Writing 1 to bit 1 changes neither.
- R6: A `usb_rx_done` strobe while `usb_bank_free` is low drives `usb_rx_nak` high for exactly the next `uclk` cycle. It leaves bit 1, the byte count and `usb_bank_free` unchanged.
- R7: `irq` equals (bit 0 AND bit 3) OR (bit 1 AND bit 4). Bits 3 and 4 are interrupt enables, loaded from `wr_data` on every write.
- R8: A write that clears a set bit 1 or sets a clear bit 2 holds `busy` high from the next `pclk` cycle. It stays high for at least LONG_HOLD (5) cycles and until the USB side has applied the command. With the default clocks it falls within 16 cycles.
- R9: Any other write holds `busy` high for exactly SHORT_HOLD (2) `pclk` cycles.
- R10: When a hardware set of transmit-done and a firmware write of 0 to bit 0 land in the same `pclk` cycle, the flag ends that cycle set.
- R11: A `usb_in_ack` strobe while `usb_tx_req` is low has no effect.
- R12: Writing 0 to bit 2 has no effect on transmit-ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Peripheral (register) clock |
| prst_n | input | 1 | Synchronous active-low reset, `pclk` domain |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 5 | Write value: bits 0..2 flags, 3..4 enables |
| rd_data | output | CNT_W+8 | Status word: flags, enables, byte count at [15:8] |
| irq | output | 1 | Interrupt request |
| busy | output | 1 | Buffer access must wait while high |
| uclk | input | 1 | USB engine clock |
| urst_n | input | 1 | Synchronous active-low reset, `uclk` domain |
| usb_rx_done | input | 1 | Engine strobe: a packet has been received |
| usb_rx_count | input | CNT_W | Byte count of that packet |
| usb_in_ack | input | 1 | Engine strobe: host acknowledged the IN packet |
| usb_tx_req | output | 1 | Packet is armed for transmit |
| usb_bank_free | output | 1 | Receive bank may accept a packet |
| usb_rx_nak | output | 1 | One-cycle pulse: packet refused, bank busy |

## Verification
The hardest case to reach is a hardware set of transmit-done that lands in the same peripheral cycle as a firmware clear. The event's arrival cycle depends on two unrelated clocks and a synchronizer. The stimulus does not aim for that cycle. Instead it writes 0 to the register on every `pclk` cycle while the engine acknowledges an armed packet. The flag must then be seen high on exactly one sample: with set priority it survives one edge, and with clear priority it is never seen.

// File: rtl/ep_csr_pkg.sv
`timescale 1ns/1ps
// Package: field positions of the endpoint status word shared by the
// register slice and the bench-facing documentation. Assumes the byte
// count field starts at bit CNT_LSB and that flags sit in the low bits.
package ep_csr_pkg;
    localparam int F_TXDONE = 0;   // hardware-set, firmware clears with 0
    localparam int F_RXFULL = 1;   // hardware-set, firmware clears with 0
    localparam int F_TXRDY  = 2;   // firmware sets with 1, hardware clears
    localparam int F_IE_TX  = 3;   // interrupt enable for F_TXDONE
    localparam int F_IE_RX  = 4;   // interrupt enable for F_RXFULL
    localparam int WR_W     = 5;   // writable bits
    localparam int CNT_LSB  = 8;   // byte count field position

    // Command sent from the bus side to the USB side
    typedef struct packed {
        logic release_bank;
        logic arm_tx;
    } ep_cmd_t;
endpackage

// File: rtl/ep_toggle_sync.sv
`timescale 1ns/1ps
// Module: toggle-handshake pulse synchronizer with payload.
// A source pulse flips a toggle and captures the payload; the destination
// detects the toggle change after STAGES flops and emits one pulse with the
// held payload; the destination toggle returns through STAGES flops as the
// acknowledge. Assumes no new source pulse while src_busy is high (such a
// pulse is dropped) and STAGES >= 2.
module ep_toggle_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             src_clk,
    input  logic             src_rst_n,
    input  logic             src_pulse,
    input  logic [WIDTH-1:0] src_data,
    output logic             src_busy,
    input  logic             dst_clk,
    input  logic             dst_rst_n,
    output logic             dst_pulse,
    output logic [WIDTH-1:0] dst_data
);
    logic              src_tgl;
    logic [WIDTH-1:0]  hold_q;
    logic [STAGES-1:0] ack_sync;
    logic [STAGES-1:0] fwd_sync;
    logic              dst_tgl;

    // Source: flip the toggle and hold the payload for each accepted pulse
    always_ff @(posedge src_clk) begin
        if (!src_rst_n) begin
            src_tgl <= 1'b0;
            hold_q  <= '0;
        end else if (src_pulse && !src_busy) begin
            src_tgl <= ~src_tgl;
            hold_q  <= src_data;
        end
    end

    // Source: bring the destination toggle back as the acknowledge
    always_ff @(posedge src_clk) begin
        if (!src_rst_n) ack_sync <= '0;
        else            ack_sync <= {ack_sync[STAGES-2:0], dst_tgl};
    end

    assign src_busy = src_tgl ^ ack_sync[STAGES-1];

    // Destination: synchronize the toggle and remember the last seen value
    always_ff @(posedge dst_clk) begin
        if (!dst_rst_n) begin
            fwd_sync <= '0;
            dst_tgl  <= 1'b0;
        end else begin
            fwd_sync <= {fwd_sync[STAGES-2:0], src_tgl};
            dst_tgl  <= fwd_sync[STAGES-1];
        end
    end

    assign dst_pulse = fwd_sync[STAGES-1] ^ dst_tgl;
    assign dst_data  = hold_q;

    // R8: a command must never be launched into a crossing still in flight
    // R8
    no_drop_chk: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        src_pulse |-> !src_busy);
endmodule

// File: rtl/ep_usb_side.sv
`timescale 1ns/1ps
// Module: USB-clock half of the endpoint. Owns the receive bank and the
// armed-transmit state, turns engine strobes into flag events, and queues
// those events until the return crossing is free. Assumes commands arrive
// as single-cycle pulses already synchronized to uclk.
module ep_usb_side #(
    parameter int CNT_W = 8
) (
    input  logic             uclk,
    input  logic             urst_n,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_data,
    input  logic             usb_rx_done,
    input  logic [CNT_W-1:0] usb_rx_count,
    input  logic             usb_in_ack,
    input  logic             evt_busy,
    output logic             evt_launch,
    output logic [CNT_W+1:0] evt_data,
    output logic             usb_tx_req,
    output logic             usb_bank_free,
    output logic             usb_rx_nak
);
    import ep_csr_pkg::*;

    ep_cmd_t          cmd;
    logic             cmd_rel, cmd_arm;
    logic             tx_pend, bank_free, nak_q;
    logic             acc_rx, acc_tx;
    logic             pend_tx, pend_rx;
    logic [CNT_W-1:0] pend_cnt;

    assign cmd     = ep_cmd_t'(cmd_data);
    assign cmd_rel = cmd_valid & cmd.release_bank;
    assign cmd_arm = cmd_valid & cmd.arm_tx;
    assign acc_rx  = usb_rx_done & bank_free;
    assign acc_tx  = usb_in_ack & tx_pend;

    // Armed-transmit state: set by the arm command, cleared by host ack
    always_ff @(posedge uclk) begin
        if (!urst_n)     tx_pend <= 1'b0;
        else if (acc_tx) tx_pend <= 1'b0;
        else if (cmd_arm) tx_pend <= 1'b1;
    end

    // Bank ownership: claimed by an accepted packet, returned by release
    always_ff @(posedge uclk) begin
        if (!urst_n)      bank_free <= 1'b1;
        else if (acc_rx)  bank_free <= 1'b0;
        else if (cmd_rel) bank_free <= 1'b1;
    end

    // Refusal pulse for a packet that found the bank still held
    always_ff @(posedge uclk) begin
        if (!urst_n) nak_q <= 1'b0;
        else         nak_q <= usb_rx_done & ~bank_free;
    end

    assign evt_launch = (pend_tx | pend_rx) & ~evt_busy;
    assign evt_data   = {pend_tx, pend_rx, pend_cnt};

    // Event queue: hold flag events until the return crossing accepts them
    always_ff @(posedge uclk) begin
        if (!urst_n) begin
            pend_tx  <= 1'b0;
            pend_rx  <= 1'b0;
            pend_cnt <= '0;
        end else begin
            pend_tx <= acc_tx | (pend_tx & ~evt_launch);
            pend_rx <= acc_rx | (pend_rx & ~evt_launch);
            if (acc_rx) pend_cnt <= usb_rx_count;
        end
    end

    assign usb_tx_req    = tx_pend;
    assign usb_bank_free = bank_free;
    assign usb_rx_nak    = nak_q;

    // R6
    nak_keeps_bank_chk: assert property (@(posedge uclk) disable iff (!urst_n)
        (usb_rx_done && !bank_free && !cmd_rel) |=> (usb_rx_nak && !usb_bank_free));
    // R4
    accept_claims_bank_chk: assert property (@(posedge uclk) disable iff (!urst_n)
        (usb_rx_done && usb_bank_free) |=> (!usb_bank_free && !usb_rx_nak && pend_rx));
    // R11
    idle_ack_chk: assert property (@(posedge uclk) disable iff (!urst_n)
        (usb_in_ack && !usb_tx_req && !pend_tx) |=> !pend_tx);
    // R2
    ack_clears_req_chk: assert property (@(posedge uclk) disable iff (!urst_n)
        (usb_in_ack && usb_tx_req) |=> (!usb_tx_req && pend_tx));
endmodule

// File: rtl/ep_bus_regs.sv
`timescale 1ns/1ps
// Module: peripheral-clock half of the endpoint. Holds the flags, enables
// and byte count, decodes firmware writes (0 clears an event flag, 1 keeps
// it), raises commands for the USB side and times the busy window.
// Assumes event pulses are single pclk cycles from the return crossing.
module ep_bus_regs #(
    parameter int CNT_W      = 8,
    parameter int SHORT_HOLD = 2,
    parameter int LONG_HOLD  = 5,
    localparam int WR_BITS   = ep_csr_pkg::WR_W,
    localparam int RD_W      = ep_csr_pkg::CNT_LSB + CNT_W
) (
    input  logic               pclk,
    input  logic               prst_n,
    input  logic               wr_en,
    input  logic [WR_BITS-1:0] wr_data,
    input  logic               evt_valid,
    input  logic [CNT_W+1:0]   evt_data,
    input  logic               cmd_busy,
    output logic               cmd_launch,
    output logic [1:0]         cmd_data,
    output logic [RD_W-1:0]    rd_data,
    output logic               irq,
    output logic               busy
);
    import ep_csr_pkg::*;

    localparam int HOLD_W = $clog2(LONG_HOLD + 1);

    logic              f_txdone, f_rxfull, f_txrdy, ie_tx, ie_rx;
    logic [CNT_W-1:0]  cnt_q;
    logic [HOLD_W-1:0] hold_q;
    logic              ev_tx, ev_rx;
    logic              wr_clr_tx, wr_rel, wr_arm;
    ep_cmd_t           cmd;

    assign ev_tx     = evt_valid & evt_data[CNT_W+1];
    assign ev_rx     = evt_valid & evt_data[CNT_W];
    assign wr_clr_tx = wr_en & ~wr_data[F_TXDONE];
    assign wr_rel    = wr_en & ~wr_data[F_RXFULL] & f_rxfull;
    assign wr_arm    = wr_en & wr_data[F_TXRDY] & ~f_txrdy;

    assign cmd.release_bank = wr_rel;
    assign cmd.arm_tx       = wr_arm;
    assign cmd_data         = cmd;
    assign cmd_launch       = wr_rel | wr_arm;

    // Event flags: a hardware set outranks a firmware clear in one cycle
    always_ff @(posedge pclk) begin
        if (!prst_n) begin
            f_txdone <= 1'b0;
            f_rxfull <= 1'b0;
            cnt_q    <= '0;
        end else begin
            if (ev_tx)          f_txdone <= 1'b1;
            else if (wr_clr_tx) f_txdone <= 1'b0;
            if (ev_rx)          f_rxfull <= 1'b1;
            else if (wr_rel)    f_rxfull <= 1'b0;
            if (ev_rx)          cnt_q    <= evt_data[CNT_W-1:0];
        end
    end

    // Transmit-ready: set by firmware, dropped once the packet is acked
    always_ff @(posedge pclk) begin
        if (!prst_n)     f_txrdy <= 1'b0;
        else if (ev_tx)  f_txrdy <= 1'b0;
        else if (wr_arm) f_txrdy <= 1'b1;
    end

    // Interrupt enables: plain storage loaded by every write
    always_ff @(posedge pclk) begin
        if (!prst_n) begin
            ie_tx <= 1'b0;
            ie_rx <= 1'b0;
        end else if (wr_en) begin
            ie_tx <= wr_data[F_IE_TX];
            ie_rx <= wr_data[F_IE_RX];
        end
    end

    // Settle timer: long for bank or transmit commands, short otherwise
    always_ff @(posedge pclk) begin
        if (!prst_n)             hold_q <= '0;
        else if (cmd_launch)     hold_q <= HOLD_W'(LONG_HOLD);
        else if (wr_en)          hold_q <= HOLD_W'(SHORT_HOLD);
        else if (hold_q != '0)   hold_q <= hold_q - 1'b1;
    end

    assign busy = (hold_q != '0) | cmd_busy;
    assign irq  = (f_txdone & ie_tx) | (f_rxfull & ie_rx);

    // Status word assembly; count shown only while the bank is held
    always_comb begin
        rd_data                   = '0;
        rd_data[F_TXDONE]         = f_txdone;
        rd_data[F_RXFULL]         = f_rxfull;
        rd_data[F_TXRDY]          = f_txrdy;
        rd_data[F_IE_TX]          = ie_tx;
        rd_data[F_IE_RX]          = ie_rx;
        rd_data[CNT_LSB +: CNT_W] = f_rxfull ? cnt_q : '0;
    end

    // R10
    set_wins_chk: assert property (@(posedge pclk) disable iff (!prst_n)
        ev_tx |=> rd_data[F_TXDONE]);
    // R8
    long_busy_chk: assert property (@(posedge pclk) disable iff (!prst_n)
        cmd_launch |=> (busy && hold_q == HOLD_W'(LONG_HOLD)));
    // R9
    short_busy_chk: assert property (@(posedge pclk) disable iff (!prst_n)
        wr_en |=> busy);
    // R4
    count_hidden_chk: assert property (@(posedge pclk) disable iff (!prst_n)
        !rd_data[F_RXFULL] |-> (rd_data[CNT_LSB +: CNT_W] == '0));
endmodule

// File: rtl/ep_status_reg.sv
`timescale 1ns/1ps
// Module: endpoint status register, top level. Joins the peripheral-clock
// register slice and the USB-clock bank/transmit state through two
// toggle-handshake crossings, one per direction. Assumes both resets are
// asserted together and that firmware waits for busy to fall before the
// next command-bearing write.
module ep_status_reg #(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2,
    parameter int SHORT_HOLD  = 2,
    parameter int LONG_HOLD   = 5,
    localparam int WR_BITS    = ep_csr_pkg::WR_W,
    localparam int RD_W       = ep_csr_pkg::CNT_LSB + CNT_W,
    localparam int EVT_W      = CNT_W + 2
) (
    input  logic               pclk,
    input  logic               prst_n,
    input  logic               wr_en,
    input  logic [WR_BITS-1:0] wr_data,
    output logic [RD_W-1:0]    rd_data,
    output logic               irq,
    output logic               busy,
    input  logic               uclk,
    input  logic               urst_n,
    input  logic               usb_rx_done,
    input  logic [CNT_W-1:0]   usb_rx_count,
    input  logic               usb_in_ack,
    output logic               usb_tx_req,
    output logic               usb_bank_free,
    output logic               usb_rx_nak
);
    logic             cmd_launch, cmd_busy, cmd_valid_u;
    logic [1:0]       cmd_data, cmd_data_u;
    logic             evt_launch, evt_busy, evt_valid_p;
    logic [EVT_W-1:0] evt_data, evt_data_p;

    ep_bus_regs #(
        .CNT_W(CNT_W), .SHORT_HOLD(SHORT_HOLD), .LONG_HOLD(LONG_HOLD)
    ) u_bus (
        .pclk(pclk), .prst_n(prst_n), .wr_en(wr_en), .wr_data(wr_data),
        .evt_valid(evt_valid_p), .evt_data(evt_data_p), .cmd_busy(cmd_busy),
        .cmd_launch(cmd_launch), .cmd_data(cmd_data),
        .rd_data(rd_data), .irq(irq), .busy(busy)
    );

    ep_toggle_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_cmd_xing (
        .src_clk(pclk), .src_rst_n(prst_n), .src_pulse(cmd_launch),
        .src_data(cmd_data), .src_busy(cmd_busy),
        .dst_clk(uclk), .dst_rst_n(urst_n), .dst_pulse(cmd_valid_u),
        .dst_data(cmd_data_u)
    );

    ep_usb_side #(.CNT_W(CNT_W)) u_usb (
        .uclk(uclk), .urst_n(urst_n),
        .cmd_valid(cmd_valid_u), .cmd_data(cmd_data_u),
        .usb_rx_done(usb_rx_done), .usb_rx_count(usb_rx_count),
        .usb_in_ack(usb_in_ack), .evt_busy(evt_busy),
        .evt_launch(evt_launch), .evt_data(evt_data),
        .usb_tx_req(usb_tx_req), .usb_bank_free(usb_bank_free),
        .usb_rx_nak(usb_rx_nak)
    );

    ep_toggle_sync #(.WIDTH(EVT_W), .STAGES(SYNC_STAGES)) u_evt_xing (
        .src_clk(uclk), .src_rst_n(urst_n), .src_pulse(evt_launch),
        .src_data(evt_data), .src_busy(evt_busy),
        .dst_clk(pclk), .dst_rst_n(prst_n), .dst_pulse(evt_valid_p),
        .dst_data(evt_data_p)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge pclk) !prst_n |=> (!irq && rd_data == '0));
endmodule

// File: tb/ep_status_reg_test.sv
`timescale 1ns/1ps
// Bench: vector table walked by one loop, then directed busy, refusal and
// set-versus-clear collision tests.
module ep_status_reg_test;
    logic        pclk = 1'b0, uclk = 1'b0;
    logic        prst_n = 1'b0, urst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_data = '0;
    logic [15:0] rd_data;
    logic        irq, busy;
    logic        usb_rx_done = 1'b0, usb_in_ack = 1'b0;
    logic [7:0]  usb_rx_count = '0;
    logic        usb_tx_req, usb_bank_free, usb_rx_nak;

    int n_cmp = 0, n_bad = 0, seen = 0, nb = 0;

    always #10   pclk = ~pclk;   // 50 MHz
    always #10.5 uclk = ~uclk;

    ep_status_reg uut (
        .pclk(pclk), .prst_n(prst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .irq(irq), .busy(busy),
        .uclk(uclk), .urst_n(urst_n), .usb_rx_done(usb_rx_done),
        .usb_rx_count(usb_rx_count), .usb_in_ack(usb_in_ack),
        .usb_tx_req(usb_tx_req), .usb_bank_free(usb_bank_free),
        .usb_rx_nak(usb_rx_nak)
    );

    // op: 0 write, 1 receive strobe, 2 host ack | arg | rd | irq | free | txreq
    localparam int NV = 14;
    localparam logic [36:0] VECS [NV] = '{
        {2'd0, 16'h0004, 16'h0004, 1'b0, 1'b1, 1'b1},
        {2'd2, 16'h0000, 16'h0001, 1'b0, 1'b1, 1'b0},
        {2'd0, 16'h0009, 16'h0009, 1'b1, 1'b1, 1'b0},
        {2'd0, 16'h0008, 16'h0008, 1'b0, 1'b1, 1'b0},
        {2'd1, 16'h002A, 16'h2A0A, 1'b0, 1'b0, 1'b0},
        {2'd0, 16'h001A, 16'h2A1A, 1'b1, 1'b0, 1'b0},
        {2'd1, 16'h0005, 16'h2A1A, 1'b1, 1'b0, 1'b0},
        {2'd0, 16'h0018, 16'h0018, 1'b0, 1'b1, 1'b0},
        {2'd1, 16'h0040, 16'h401A, 1'b1, 1'b0, 1'b0},
        {2'd0, 16'h0000, 16'h0000, 1'b0, 1'b1, 1'b0},
        {2'd2, 16'h0000, 16'h0000, 1'b0, 1'b1, 1'b0},
        {2'd0, 16'h0004, 16'h0004, 1'b0, 1'b1, 1'b1},
        {2'd0, 16'h0003, 16'h0004, 1'b0, 1'b1, 1'b1},
        {2'd2, 16'h0000, 16'h0001, 1'b0, 1'b1, 1'b0}
    };

    function automatic string vec_req(input int i);
        case (i)
            0, 1, 13: return "R2";
            2:        return "R7";
            3:        return "R3";
            4, 8:     return "R4";
            5, 7, 9:  return "R5";
            6:        return "R6";
            10:       return "R11";
            default:  return "R12";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] d);
        @(negedge pclk); wr_en = 1'b1; wr_data = d;
        @(negedge pclk); wr_en = 1'b0;
    endtask

    task automatic rx_strobe(input logic [7:0] c);
        @(negedge uclk); usb_rx_done = 1'b1; usb_rx_count = c;
        @(negedge uclk); usb_rx_done = 1'b0;
    endtask

    task automatic ack_strobe();
        @(negedge uclk); usb_in_ack = 1'b1;
        @(negedge uclk); usb_in_ack = 1'b0;
    endtask

    // Long busy window: count samples with busy high after the write
    task automatic long_busy(input logic [4:0] d, input string req);
        @(negedge pclk); wr_en = 1'b1; wr_data = d;
        @(negedge pclk); wr_en = 1'b0;
        nb = 0;
        while (busy && nb < 40) begin nb++; @(negedge pclk); end
        check(req, "busy cycles at least LONG_HOLD", 32'(nb >= 5), 32'd1);
        check(req, "busy cycles bounded", 32'(nb <= 16), 32'd1);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge pclk);
        n_bad++; n_cmp++;
        $display("FAIL watchdog: actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (5) @(negedge pclk);
        prst_n = 1'b1; urst_n = 1'b1;
        repeat (3) @(negedge pclk);
        // R1: reset state
        check("R1", "rd_data", 32'(rd_data), 32'h0);
        check("R1", "irq", 32'(irq), 32'h0);
        check("R1", "busy", 32'(busy), 32'h0);
        check("R1", "usb_tx_req", 32'(usb_tx_req), 32'h0);
        check("R1", "usb_bank_free", 32'(usb_bank_free), 32'h1);
        check("R1", "usb_rx_nak", 32'(usb_rx_nak), 32'h0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            case (VECS[i][36:35])
                2'd0:    bus_write(VECS[i][23:19]);
                2'd1:    rx_strobe(VECS[i][26:19]);
                default: ack_strobe();
            endcase
            repeat (30) @(negedge pclk);
            check(vec_req(i), $sformatf("step %0d rd_data", i), 32'(rd_data), 32'(VECS[i][18:3]));
            check(vec_req(i), $sformatf("step %0d irq", i), 32'(irq), 32'(VECS[i][2]));
            check(vec_req(i), $sformatf("step %0d bank_free", i), 32'(usb_bank_free), 32'(VECS[i][1]));
            check(vec_req(i), $sformatf("step %0d tx_req", i), 32'(usb_tx_req), 32'(VECS[i][0]));
        end

        // R9: plain write holds busy for exactly two cycles
        @(negedge pclk); wr_en = 1'b1; wr_data = 5'h00;
        @(negedge pclk); wr_en = 1'b0;
        check("R9", "busy cycle 1", 32'(busy), 32'h1);
        @(negedge pclk);
        check("R9", "busy cycle 2", 32'(busy), 32'h1);
        @(negedge pclk);
        check("R9", "busy released", 32'(busy), 32'h0);

        // R8: arming a transmit holds busy until the request is visible
        repeat (5) @(negedge pclk);
        long_busy(5'h04, "R8");
        check("R8", "tx_req when busy falls", 32'(usb_tx_req), 32'h1);
        ack_strobe();
        repeat (30) @(negedge pclk);

        // R6: packet refused while the bank is held
        rx_strobe(8'h11);
        repeat (30) @(negedge pclk);
        @(negedge uclk); usb_rx_done = 1'b1; usb_rx_count = 8'h7F;
        @(negedge uclk); usb_rx_done = 1'b0;
        check("R6", "nak pulse", 32'(usb_rx_nak), 32'h1);
        @(negedge uclk);
        check("R6", "nak one cycle", 32'(usb_rx_nak), 32'h0);
        repeat (30) @(negedge pclk);
        check("R6", "count kept", 32'(rd_data[15:8]), 32'h11);
        check("R6", "bank still held", 32'(usb_bank_free), 32'h0);

        // R8: releasing the bank holds busy until the bank is free
        long_busy(5'h00, "R8");
        check("R8", "bank free when busy falls", 32'(usb_bank_free), 32'h1);

        // R10: host ack lands while firmware writes 0 every cycle
        repeat (5) @(negedge pclk);
        bus_write(5'h04);
        repeat (40) @(negedge pclk);
        seen = 0;
        fork
            begin
                @(negedge pclk); wr_en = 1'b1; wr_data = 5'h00;
                for (int k = 0; k < 40; k++) begin
                    @(negedge pclk);
                    if (rd_data[0]) seen++;
                end
                wr_en = 1'b0;
            end
            begin
                repeat (6) @(negedge uclk);
                usb_in_ack = 1'b1;
                @(negedge uclk); usb_in_ack = 1'b0;
            end
        join
        check("R10", "cycles transmit-done seen", 32'(seen), 32'd1);
        check("R10", "transmit-ready dropped", 32'(rd_data[2]), 32'h0);

        summary();
        $finish;
    end
endmodule